// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sits between a requester and an AUX channel transaction engine. When it is started with a direction, a byte length and a defer delay, it sends one request to the engine and waits for the engine to finish. The engine returns an operation result, a reply code and a count of returned bytes. From these three values the controller chooses one of three outcomes: pass, fail, or retry after a wait.

Each kind of failure has its own retry counter and its own budget. Waits are counted in microsecond ticks that come from an external strobe. The controller also keeps a running total of defer time. If a write is acknowledged but the sink asks for more time, the controller changes the next request into a zero-length write-status poll.

At the end of a run the controller pulses a done output for one cycle, with a pass or fail flag beside it.

Top module: `aux_retry_ctrl`

## Requirements
- R1: A run makes at most 7 requests. If a retry is chosen after the 7th response, the controller first finishes that retry's wait and then ends with fail.
- R2: A response with result 0 (success) and reply 0x0 (ACK) passes when it is a read that returned exactly the requested byte count, or a write that returned zero bytes.
- R3: A success/ACK on a read that returned a byte count different from the request is retried after 300 ticks. The run fails when the 7th such response arrives.
- R4: A success/ACK on a write with a nonzero returned count is retried after 300 ticks as a status poll. That poll has the write flag low, the status flag high and a length of 0. The limit is 7.
- R5: A native DEFER (reply 0x2) adds 1 to the defer count, adds the poll period (1000) to the defer time and marks that a defer has been seen. If the run does not give up, the retry waits the defer delay and adds that delay to the defer time.
- R6: A native DEFER or an I2C NACK (reply 0x4) ends the run only when the defer count is at least 7 and the defer time is at least 50000. In that case the run fails with no further wait.
- R7: An I2C DEFER (reply 0x8) clears the defer count and is retried at once. The run fails on the 7th I2C DEFER.
- R8: A native NACK (reply 0x1), any reply code outside {0x0,0x1,0x2,0x4,0x8}, result 3 (hot-plug loss) and result 4 (engine not acquired) each fail at once.
- R9: Result 1 (invalid reply) is retried after 400 ticks. The run fails on the second invalid reply.
- R10: Result 2 (timeout) counts as a defer, with limit 7 and the defer delay as its wait, once a defer has been seen. Before that it counts toward a limit of 3 and is retried with no wait.
- R11: Any response with result 0 clears the timeout count and the invalid-reply count.
- R12: After reset, done, pass and the request strobe are low. Done and the request strobe are each high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick_i | input | 1 | One-cycle strobe for each microsecond |
| start_i | input | 1 | Begins a run; sampled only while idle |
| write_i | input | 1 | The run is a write |
| len_i | input | LEN_W | Requested byte count |
| defer_dly_i | input | DLY_W | Wait after a defer, in ticks |
| txn_req_o | output | 1 | One-cycle request to the engine |
| txn_write_o | output | 1 | Current request is a write |
| txn_stat_o | output | 1 | Current request is a write-status poll |
| txn_len_o | output | LEN_W | Current request length |
| txn_done_i | input | 1 | Engine has finished the request |
| txn_res_i | input | 3 | Operation result |
| txn_reply_i | input | 4 | Reply code |
| txn_bytes_i | input | LEN_W | Returned byte count |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Outcome of the last run |

## Verification
Four properties are checked on every cycle: the two strobes are single-cycle pulses, no run sends more than the request budget, and a status poll always carries zero length and a low write flag. Only the bench scenarios can show the rest: which reply sequences pass and which fail, how long each retry waits, that a success clears the timeout and invalid budgets, that a timeout turns into a defer once a defer has been seen, and that giving up on defers depends on both the count and the time total.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned DTIME_W = 20;

  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_INVALID = 3'd1;
  localparam logic [2:0] RES_TIMEOUT = 3'd2;

  localparam logic [3:0] RPL_ACK       = 4'h0;
  localparam logic [3:0] RPL_NACK      = 4'h1;
  localparam logic [3:0] RPL_DEFER     = 4'h2;
  localparam logic [3:0] RPL_I2C_NACK  = 4'h4;
  localparam logic [3:0] RPL_I2C_DEFER = 4'h8;

  typedef enum logic [1:0] {ACT_PASS, ACT_FAIL, ACT_RETRY} act_e;

  typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_EVAL, ST_DELAY} st_e;

  typedef struct packed {
    logic [CNT_W-1:0]   ack_short;
    logic [CNT_W-1:0]   ack_more;
    logic [CNT_W-1:0]   dfr;
    logic [CNT_W-1:0]   i2c_dfr;
    logic [CNT_W-1:0]   tmo;
    logic [CNT_W-1:0]   inv;
    logic               dfr_seen;
    logic [DTIME_W-1:0] dtime;
  } tally_t;
endpackage

// File: rtl/aux_retry_timer.sv
module aux_retry_timer #(
  parameter int unsigned WAIT_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] val_i,
  input  logic              tick_i,
  output logic              busy_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/aux_retry_decide.sv
module aux_retry_decide
  import aux_retry_pkg::*;
#(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned DLY_W      = 16,
  parameter int unsigned WAIT_W     = 17,
  parameter int unsigned ACK_LIMIT  = 7,
  parameter int unsigned DFR_LIMIT  = 7,
  parameter int unsigned I2C_LIMIT  = 7,
  parameter int unsigned TMO_LIMIT  = 3,
  parameter int unsigned INV_LIMIT  = 2,
  parameter int unsigned ACK_WAIT   = 300,
  parameter int unsigned INV_WAIT   = 400,
  parameter int unsigned POLL_US    = 1000,
  parameter int unsigned DFR_BUDGET = 50000
) (
  input  logic [2:0]        res_i,
  input  logic [3:0]        reply_i,
  input  logic [LEN_W-1:0]  bytes_i,
  input  logic              req_write_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [DLY_W-1:0]  defer_dly_i,
  input  tally_t            tally_i,
  output act_e              act_o,
  output logic [WAIT_W-1:0] wait_o,
  output tally_t            tally_o,
  output logic              to_status_o
);
  always_comb begin
    act_o       = ACT_FAIL;
    wait_o      = '0;
    tally_o     = tally_i;
    to_status_o = 1'b0;
    case (res_i)
      RES_OK: begin
        // R11: a good transfer refunds the timeout and invalid budgets
        tally_o.tmo = '0;
        tally_o.inv = '0;
        case (reply_i)
          RPL_ACK: begin
            if (!req_write_i && bytes_i != req_len_i) begin
              tally_o.ack_short = tally_i.ack_short + 1'b1;
              if (tally_o.ack_short >= CNT_W'(ACK_LIMIT)) act_o = ACT_FAIL;
              else begin
                act_o  = ACT_RETRY;
                wait_o = WAIT_W'(ACK_WAIT);
              end
            end else if (req_write_i && bytes_i != '0) begin
              tally_o.ack_more = tally_i.ack_more + 1'b1;
              if (tally_o.ack_more >= CNT_W'(ACK_LIMIT)) act_o = ACT_FAIL;
              else begin
                act_o       = ACT_RETRY;
                wait_o      = WAIT_W'(ACK_WAIT);
                to_status_o = 1'b1;
              end
            end else begin
              act_o = ACT_PASS;
            end
          end
          RPL_DEFER, RPL_I2C_NACK: begin
            if (reply_i == RPL_DEFER) begin
              tally_o.dfr      = tally_i.dfr + 1'b1;
              tally_o.dtime    = tally_i.dtime + DTIME_W'(POLL_US);
              tally_o.dfr_seen = 1'b1;
            end
            if (tally_o.dfr >= CNT_W'(DFR_LIMIT) &&
                tally_o.dtime >= DTIME_W'(DFR_BUDGET)) begin
              act_o = ACT_FAIL;
            end else begin
              act_o = ACT_RETRY;
              if (reply_i == RPL_DEFER) begin
                wait_o        = WAIT_W'(defer_dly_i);
                tally_o.dtime = tally_o.dtime + DTIME_W'(defer_dly_i);
              end
            end
          end
          RPL_I2C_DEFER: begin
            tally_o.dfr     = '0;
            tally_o.i2c_dfr = tally_i.i2c_dfr + 1'b1;
            act_o = (tally_o.i2c_dfr >= CNT_W'(I2C_LIMIT)) ? ACT_FAIL : ACT_RETRY;
          end
          default: act_o = ACT_FAIL;
        endcase
      end
      RES_INVALID: begin
        tally_o.inv = tally_i.inv + 1'b1;
        if (tally_o.inv >= CNT_W'(INV_LIMIT)) act_o = ACT_FAIL;
        else begin
          act_o  = ACT_RETRY;
          wait_o = WAIT_W'(INV_WAIT);
        end
      end
      RES_TIMEOUT: begin
        if (tally_i.dfr_seen) begin
          tally_o.dfr = tally_i.dfr + 1'b1;
          if (tally_o.dfr >= CNT_W'(DFR_LIMIT)) act_o = ACT_FAIL;
          else begin
            act_o  = ACT_RETRY;
            wait_o = WAIT_W'(defer_dly_i);
          end
        end else begin
          tally_o.tmo = tally_i.tmo + 1'b1;
          act_o = (tally_o.tmo >= CNT_W'(TMO_LIMIT)) ? ACT_FAIL : ACT_RETRY;
        end
      end
      default: act_o = ACT_FAIL;
    endcase
  end
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned DLY_W      = 16,
  parameter int unsigned WAIT_W     = 17,
  parameter int unsigned ATT_LIMIT  = 7,
  parameter int unsigned ACK_LIMIT  = 7,
  parameter int unsigned DFR_LIMIT  = 7,
  parameter int unsigned I2C_LIMIT  = 7,
  parameter int unsigned TMO_LIMIT  = 3,
  parameter int unsigned INV_LIMIT  = 2,
  parameter int unsigned ACK_WAIT   = 300,
  parameter int unsigned INV_WAIT   = 400,
  parameter int unsigned POLL_US    = 1000,
  parameter int unsigned DFR_BUDGET = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick_i,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DLY_W-1:0] defer_dly_i,
  output logic             txn_req_o,
  output logic             txn_write_o,
  output logic             txn_stat_o,
  output logic [LEN_W-1:0] txn_len_o,
  input  logic             txn_done_i,
  input  logic [2:0]       txn_res_i,
  input  logic [3:0]       txn_reply_i,
  input  logic [LEN_W-1:0] txn_bytes_i,
  output logic             done_o,
  output logic             pass_o
);
  localparam int unsigned ATT_W = $clog2(ATT_LIMIT + 1);

  st_e              state_q;
  tally_t           tally_q, tally_nxt;
  logic [ATT_W-1:0] att_q;
  logic [DLY_W-1:0] dly_q;
  logic [2:0]       res_q;
  logic [3:0]       reply_q;
  logic [LEN_W-1:0] bytes_q;
  act_e             act;
  logic [WAIT_W-1:0] wait_val;
  logic             to_status, tmr_busy, tmr_load;

  aux_retry_decide #(
    .LEN_W(LEN_W), .DLY_W(DLY_W), .WAIT_W(WAIT_W),
    .ACK_LIMIT(ACK_LIMIT), .DFR_LIMIT(DFR_LIMIT), .I2C_LIMIT(I2C_LIMIT),
    .TMO_LIMIT(TMO_LIMIT), .INV_LIMIT(INV_LIMIT), .ACK_WAIT(ACK_WAIT),
    .INV_WAIT(INV_WAIT), .POLL_US(POLL_US), .DFR_BUDGET(DFR_BUDGET)
  ) u_decide (
    .res_i(res_q), .reply_i(reply_q), .bytes_i(bytes_q),
    .req_write_i(txn_write_o), .req_len_i(txn_len_o),
    .defer_dly_i(dly_q), .tally_i(tally_q),
    .act_o(act), .wait_o(wait_val), .tally_o(tally_nxt),
    .to_status_o(to_status)
  );

  assign tmr_load = (state_q == ST_EVAL) && (act == ACT_RETRY);

  aux_retry_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(wait_val),
    .tick_i(us_tick_i), .busy_o(tmr_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      tally_q     <= '0;
      att_q       <= '0;
      dly_q       <= '0;
      res_q       <= '0;
      reply_q     <= '0;
      bytes_q     <= '0;
      txn_req_o   <= 1'b0;
      txn_write_o <= 1'b0;
      txn_stat_o  <= 1'b0;
      txn_len_o   <= '0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
    end else begin
      txn_req_o <= 1'b0;
      done_o    <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          txn_write_o <= write_i;
          txn_stat_o  <= 1'b0;
          txn_len_o   <= len_i;
          dly_q       <= defer_dly_i;
          tally_q     <= '0;
          att_q       <= '0;
          state_q     <= ST_ISSUE;
        end
        ST_ISSUE: begin
          txn_req_o <= 1'b1;
          att_q     <= att_q + 1'b1;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: if (txn_done_i) begin
          res_q   <= txn_res_i;
          reply_q <= txn_reply_i;
          bytes_q <= txn_bytes_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          tally_q <= tally_nxt;
          case (act)
            ACT_PASS: begin
              done_o  <= 1'b1;
              pass_o  <= 1'b1;
              state_q <= ST_IDLE;
            end
            ACT_FAIL: begin
              done_o  <= 1'b1;
              pass_o  <= 1'b0;
              state_q <= ST_IDLE;
            end
            default: begin
              if (to_status) begin
                txn_write_o <= 1'b0;
                txn_stat_o  <= 1'b1;
                txn_len_o   <= '0;
              end
              state_q <= ST_DELAY;
            end
          endcase
        end
        ST_DELAY: if (!tmr_busy) begin
          if (att_q >= ATT_W'(ATT_LIMIT)) begin
            done_o  <= 1'b1;
            pass_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk #(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned ATT_LIMIT = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             txn_req_o,
  input logic             txn_write_o,
  input logic             txn_stat_o,
  input logic [LEN_W-1:0] txn_len_o,
  input logic             done_o
);
  localparam int unsigned RC_W = $clog2(ATT_LIMIT + 2) + 1;
  logic [RC_W-1:0] reqs_q;

  always_ff @(posedge clk) begin
    if (rst || done_o)  reqs_q <= '0;
    else if (txn_req_o) reqs_q <= reqs_q + 1'b1;
  end

  // R1
  req_budget_chk: assert property (@(posedge clk) disable iff (rst)
    reqs_q <= RC_W'(ATT_LIMIT));
  // R4
  status_poll_shape_chk: assert property (@(posedge clk) disable iff (rst)
    txn_stat_o |-> (txn_len_o == '0 && !txn_write_o));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    txn_req_o |=> !txn_req_o);
  // R12
  req_done_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(txn_req_o && done_o));
endmodule

bind aux_retry_ctrl aux_retry_chk #(.LEN_W(LEN_W), .ATT_LIMIT(ATT_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .txn_req_o(txn_req_o), .txn_write_o(txn_write_o),
  .txn_stat_o(txn_stat_o), .txn_len_o(txn_len_o), .done_o(done_o)
);

// File: tb/tb_aux_retry_ctrl.sv
module tb_aux_retry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic            wr;
    logic [7:0]      len;
    logic [15:0]     dly;
    logic            pass;
    logic [3:0]      att;
    logic [6:0][14:0] rsp;
  } scen_t;

  function automatic logic [14:0] mk(input logic [2:0] r, input logic [3:0] c, input logic [7:0] b);
    return {r, c, b};
  endfunction
  function automatic logic [104:0] seq7(input logic [14:0] a, b, c, d, e, f, g);
    return {a, b, c, d, e, f, g};
  endfunction

  localparam logic [14:0] A4 = mk(3'd0, 4'h0, 8'd4);
  localparam logic [14:0] A2 = mk(3'd0, 4'h0, 8'd2);
  localparam logic [14:0] A1 = mk(3'd0, 4'h0, 8'd1);
  localparam logic [14:0] A0 = mk(3'd0, 4'h0, 8'd0);
  localparam logic [14:0] NK = mk(3'd0, 4'h1, 8'd0);
  localparam logic [14:0] DF = mk(3'd0, 4'h2, 8'd0);
  localparam logic [14:0] IN = mk(3'd0, 4'h4, 8'd0);
  localparam logic [14:0] ID = mk(3'd0, 4'h8, 8'd0);
  localparam logic [14:0] UK = mk(3'd0, 4'h5, 8'd0);
  localparam logic [14:0] IV = mk(3'd1, 4'h0, 8'd0);
  localparam logic [14:0] TO = mk(3'd2, 4'h0, 8'd0);
  localparam logic [14:0] HP = mk(3'd3, 4'h0, 8'd0);
  localparam logic [14:0] AQ = mk(3'd4, 4'h0, 8'd0);

  localparam scen_t TBL [NV] = '{
    '{1'b0, 8'd4, 16'd0,    1'b1, 4'd1, seq7(A4, A4, A4, A4, A4, A4, A4)}, // R2
    '{1'b0, 8'd4, 16'd0,    1'b1, 4'd2, seq7(A2, A4, A4, A4, A4, A4, A4)}, // R3
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd1, seq7(NK, A4, A4, A4, A4, A4, A4)}, // R8
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd1, seq7(HP, A4, A4, A4, A4, A4, A4)}, // R8
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd1, seq7(AQ, A4, A4, A4, A4, A4, A4)}, // R8
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd1, seq7(UK, A4, A4, A4, A4, A4, A4)}, // R8
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd2, seq7(IV, IV, A4, A4, A4, A4, A4)}, // R9
    '{1'b0, 8'd4, 16'd0,    1'b1, 4'd4, seq7(IV, A2, IV, A4, A4, A4, A4)}, // R11
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd3, seq7(TO, TO, TO, A4, A4, A4, A4)}, // R10
    '{1'b0, 8'd4, 16'd0,    1'b1, 4'd6, seq7(TO, TO, A2, TO, TO, A4, A4)}, // R11
    '{1'b0, 8'd4, 16'd10,   1'b1, 4'd5, seq7(DF, TO, TO, TO, A4, A4, A4)}, // R10 R5
    '{1'b0, 8'd4, 16'd0,    1'b1, 4'd7, seq7(ID, ID, ID, ID, ID, ID, A4)}, // R7
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd7, seq7(ID, ID, ID, ID, ID, ID, ID)}, // R7
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd7, seq7(A2, A2, A2, A2, A2, A2, A2)}, // R3
    '{1'b0, 8'd4, 16'd20,   1'b0, 4'd7, seq7(DF, DF, DF, DF, DF, DF, DF)}, // R1 R5
    '{1'b1, 8'd2, 16'd0,    1'b1, 4'd2, seq7(A1, A0, A4, A4, A4, A4, A4)}, // R4
    '{1'b0, 8'd4, 16'd0,    1'b0, 4'd7, seq7(IN, IN, IN, IN, IN, IN, IN)}  // R1 R6
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, write_i = 1'b0;
  logic [7:0] len_i = '0, txn_bytes_i = '0, txn_len_o;
  logic [15:0] defer_dly_i = '0;
  logic txn_req_o, txn_write_o, txn_stat_o, txn_done_i, done_o, pass_o;
  logic [2:0] txn_res_i = '0;
  logic [3:0] txn_reply_i = '0;

  int cyc = 0, nchk = 0, nerr = 0, req_cnt = 0, done_cyc = 0;
  int req_at [8], done_at [8];
  logic wr_seen [8], st_seen [8];
  logic [7:0] len_seen [8];
  logic [6:0][14:0] cur;
  logic got_pass;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aux_retry_ctrl dut (
    .clk(clk), .rst(rst), .us_tick_i(1'b1), .start_i(start_i), .write_i(write_i),
    .len_i(len_i), .defer_dly_i(defer_dly_i), .txn_req_o(txn_req_o),
    .txn_write_o(txn_write_o), .txn_stat_o(txn_stat_o), .txn_len_o(txn_len_o),
    .txn_done_i(txn_done_i), .txn_res_i(txn_res_i), .txn_reply_i(txn_reply_i),
    .txn_bytes_i(txn_bytes_i), .done_o(done_o), .pass_o(pass_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // mock transaction engine
  initial begin
    logic [14:0] r;
    txn_done_i = 1'b0;
    forever begin
      @(negedge clk);
      if (txn_req_o) begin
        if (req_cnt < 8) begin
          req_at[req_cnt]   = cyc;
          wr_seen[req_cnt]  = txn_write_o;
          st_seen[req_cnt]  = txn_stat_o;
          len_seen[req_cnt] = txn_len_o;
        end
        r = (req_cnt < 7) ? cur[6 - req_cnt] : A4;
        repeat (2) @(negedge clk);
        txn_res_i   = r[14:12];
        txn_reply_i = r[11:8];
        txn_bytes_i = r[7:0];
        txn_done_i  = 1'b1;
        if (req_cnt < 8) done_at[req_cnt] = cyc;
        req_cnt++;
        @(negedge clk);
        txn_done_i = 1'b0;
      end
    end
  end

  task automatic run(input scen_t s);
    cur = s.rsp;
    req_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; write_i = s.wr; len_i = s.len; defer_dly_i = s.dly;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    done_cyc = cyc;
    got_pass = pass_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R12 done lasts one cycle", done_o, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R12 reset done", done_o, 0);
    chk(pass_o == 1'b0, "R12 reset pass", pass_o, 0);
    chk(txn_req_o == 1'b0, "R12 reset request", txn_req_o, 0);

    for (int i = 0; i < NV; i++) begin
      run(TBL[i]);
      chk(got_pass == TBL[i].pass, $sformatf("row %0d outcome (R1-tagged rows above)", i), got_pass, TBL[i].pass);
      chk(req_cnt == int'(TBL[i].att), $sformatf("row %0d request count", i), req_cnt, TBL[i].att);
    end

    // R3: short read retried after 300 ticks
    run(TBL[1]);
    chk(req_at[1] - done_at[0] >= 300 && req_at[1] - done_at[0] <= 310,
        "R3 ack retry wait", req_at[1] - done_at[0], 303);
    // R9: invalid reply retried after 400 ticks
    run('{1'b0, 8'd4, 16'd0, 1'b1, 4'd2, seq7(IV, A4, A4, A4, A4, A4, A4)});
    chk(got_pass == 1'b1, "R9 single invalid then pass", got_pass, 1);
    chk(req_at[1] - done_at[0] >= 400 && req_at[1] - done_at[0] <= 410,
        "R9 invalid retry wait", req_at[1] - done_at[0], 403);
    // R10: timeout with no defer before it retries without waiting
    run('{1'b0, 8'd4, 16'd0, 1'b1, 4'd2, seq7(TO, A4, A4, A4, A4, A4, A4)});
    chk(req_at[1] - done_at[0] < 10, "R10 timeout no wait", req_at[1] - done_at[0], 3);
    // R4: write with more-time ack becomes a status poll
    run(TBL[15]);
    chk(wr_seen[0] == 1'b1 && len_seen[0] == 8'd2, "R4 first request is write of 2", len_seen[0], 2);
    chk(wr_seen[1] == 1'b0, "R4 poll write flag", wr_seen[1], 0);
    chk(st_seen[1] == 1'b1, "R4 poll status flag", st_seen[1], 1);
    chk(len_seen[1] == 8'd0, "R4 poll length", len_seen[1], 0);
    chk(req_at[1] - done_at[0] >= 300 && req_at[1] - done_at[0] <= 310,
        "R4 poll wait", req_at[1] - done_at[0], 303);
    // R5: defer waits the configured delay
    run('{1'b0, 8'd4, 16'd50, 1'b1, 4'd2, seq7(DF, A4, A4, A4, A4, A4, A4)});
    chk(req_at[1] - done_at[0] >= 50 && req_at[1] - done_at[0] <= 60,
        "R5 defer wait", req_at[1] - done_at[0], 53);
    // R6 + R1: 7 defers below the time budget still wait before failing
    run('{1'b0, 8'd4, 16'd2000, 1'b0, 4'd7, seq7(DF, DF, DF, DF, DF, DF, DF)});
    chk(got_pass == 1'b0 && req_cnt == 7, "R1 defer exhaustion fails", req_cnt, 7);
    chk(done_cyc - done_at[6] >= 2000, "R6 below budget waits", done_cyc - done_at[6], 2003);
    // R6: 7 defers at or over the time budget fail at once
    run('{1'b0, 8'd4, 16'd8000, 1'b0, 4'd7, seq7(DF, DF, DF, DF, DF, DF, DF)});
    chk(got_pass == 1'b0 && req_cnt == 7, "R6 over budget fails", req_cnt, 7);
    chk(done_cyc - done_at[6] < 10, "R6 over budget immediate", done_cyc - done_at[6], 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired, no requirement finished actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule